// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block connects a simple synchronous host request port to an external asynchronous memory bus such as SRAM, NOR flash or NAND flash. The host gives a byte address, a direction, write data and a one- or two-byte size over a valid/ready handshake. The top two address bits pick one of four chip selects, and each chip select covers a 64 MiB window. The block then runs the external access as a setup phase, a strobe phase and a hold phase, with every phase length counted in clock cycles.

Each chip select has its own configuration inputs. These give separate read and write setup, strobe and hold lengths, a turnaround length and a data bus width of 8 or 16 bits. They also give two mode flags. The first flag confines chip select to the strobe window. The second flag lets a per-chip-select wait input stretch the strobe. A two-byte request to an 8-bit device is split into two back-to-back external accesses. Every request ends with a one-cycle response pulse, and for reads that pulse carries the data.

Top module: `async_mem_ctrl`

## Requirements
- R1: The chip select is `req_addr[27:26]`, and `mem_addr` carries the offset `req_addr[25:0]` (plus 1 for the upper half of a split access). At most one `mem_cs_n` bit is low at any time, and every other bit stays high.
- R2: A read runs for rd_setup + rd_strobe + rd_hold cycles with `mem_oe_n` low for rd_strobe cycles. A write uses the separate write values and holds `mem_we_n` low for wr_strobe cycles. `mem_oe_n` and `mem_we_n` are never low together.
- R3: A setup, strobe or hold value of 0 behaves exactly as a value of 1.
- R4: When the previous access used a different chip select or the opposite direction, `cfg_turn` of the new chip select is inserted. This gives that many cycles with every chip select deasserted, after acceptance and before setup starts. A value of 0 inserts nothing.
- R5: A read following a read, or a write following a write, to the same chip select starts setup in the cycle right after acceptance.
- R6: With `cfg_sel_strobe` set, chip select is low only in the cycles where the strobe is low. With the flag clear, chip select is low through setup, strobe and hold.
- R7: With `cfg_ext_wait` set, `mem_wait` for that chip select is synchronised through two flops and checked in the last strobe cycle. The strobe is extended one cycle at a time while the synchronised wait is high. With the flag clear, or when wait belongs to another chip select, the strobe length is unchanged.
- R8: With `cfg_wide` = 0 (8-bit), a request with `req_two` = 1 becomes two accesses at offsets A and A+1, low byte first. The second access follows the first hold with no turnaround and no chip select gap, and each byte travels on bit lane [7:0].
- R9: `rsp_valid` is high for exactly one cycle, in the first cycle after the final hold. For a read, `rsp_rdata` holds the data. A two-byte read returns {byte at A+1, byte at A} on an 8-bit bus or the full 16-bit word on a 16-bit bus. A one-byte read returns the byte in [7:0] with [15:8] zero.
- R10: After reset `req_ready` is 1, all `mem_cs_n` bits are 1, `mem_oe_n` and `mem_we_n` are 1, and `mem_dout_en` and `rsp_valid` are 0.
- R11: `mem_dout_en` is high exactly for the setup, strobe and hold cycles of write accesses and never during a read strobe. `mem_dout` carries the write byte or word during those cycles.
- R12: `req_ready` is low from the cycle after acceptance until the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 28 | Byte address: [27:26] chip select, [25:0] offset |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data, low byte in [7:0] |
| req_two | input | 1 | 1 = two-byte access, 0 = one byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| cfg_rd_setup | input | 4x4 | Read setup cycles per chip select |
| cfg_rd_strobe | input | 4x4 | Read strobe cycles per chip select |
| cfg_rd_hold | input | 4x4 | Read hold cycles per chip select |
| cfg_wr_setup | input | 4x4 | Write setup cycles per chip select |
| cfg_wr_strobe | input | 4x4 | Write strobe cycles per chip select |
| cfg_wr_hold | input | 4x4 | Write hold cycles per chip select |
| cfg_turn | input | 4x4 | Turnaround cycles per chip select |
| cfg_wide | input | 4 | 1 = 16-bit device, 0 = 8-bit device |
| cfg_sel_strobe | input | 4 | Chip select only during strobe |
| cfg_ext_wait | input | 4 | Wait input stretches the strobe |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable (read strobe) |
| mem_we_n | output | 1 | Active-low write enable (write strobe) |
| mem_addr | output | 26 | Byte offset within the selected window |
| mem_dout | output | 16 | Write data toward the memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | 16 | Read data from the memory |
| mem_wait | input | 4 | Per-chip-select wait request |

## Verification
The bench counts strobe, chip select and drive-enable cycles for each access and measures the idle lead between acceptance and the first chip select. This catches a design that adds turnaround to same-direction repeats or leaves it out on a direction or chip select change. Zero-length timings must give one-cycle phases, so an off-by-one counter shows up as a phase of zero or two cycles. The wait tests release wait partway through a stretched strobe and expect the exact two-flop latency. They also hold wait on a chip select with the mode off, or on a different chip select, so that a design honouring the wrong wait bit lengthens the strobe. Split 8-bit accesses are checked for byte order, consecutive addresses and an unbroken chip select, which exposes a swapped half or a turnaround between halves.

// File: rtl/amc_pkg.sv
package amc_pkg;
  localparam int TIM_W = 4;

  typedef logic [TIM_W-1:0] tlen_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    tlen_t rd_setup;
    tlen_t rd_strobe;
    tlen_t rd_hold;
    tlen_t wr_setup;
    tlen_t wr_strobe;
    tlen_t wr_hold;
    tlen_t turn;
    logic  wide;
    logic  sel_strobe;
    logic  ext_wait;
  } cs_cfg_t;

  // A programmed phase length of zero is treated as one cycle.
  function automatic tlen_t at_least_one(tlen_t v);
    return (v == '0) ? tlen_t'(1) : v;
  endfunction

  // Length in cycles of the given phase for the given direction.
  function automatic tlen_t phase_len(cs_cfg_t c, logic wr, phase_e ph);
    case (ph)
      PH_TURN:   return c.turn;
      PH_SETUP:  return wr ? c.wr_setup  : c.rd_setup;
      PH_STROBE: return wr ? c.wr_strobe : c.rd_strobe;
      PH_HOLD:   return wr ? c.wr_hold   : c.rd_hold;
      default:   return tlen_t'(1);
    endcase
  endfunction

  // Merge a sampled data bus into the read accumulator.
  function automatic logic [15:0] merge_rd(logic [15:0] acc, logic [15:0] din,
                                           logic wide, logic two, logic upper);
    if (wide)  return two ? din : {8'h00, din[7:0]};
    if (upper) return {din[7:0], acc[7:0]};
    return {8'h00, din[7:0]};
  endfunction

  // Data bus contents for the current write access.
  function automatic logic [15:0] drive_wr(logic [15:0] wd, logic wide,
                                           logic two, logic upper);
    if (wide) return two ? wd : {8'h00, wd[7:0]};
    return {8'h00, upper ? wd[15:8] : wd[7:0]};
  endfunction
endpackage

// File: rtl/amc_wait_sync.sv
module amc_wait_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[g]   <= 1'b0;
        sync_out[g] <= 1'b0;
      end else begin
        stage1[g]   <= async_in[g];
        sync_out[g] <= stage1[g];
      end
    end
  end
endmodule

// File: rtl/amc_cfg_sel.sv
module amc_cfg_sel
  import amc_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input  logic [NUM_CS-1:0][TIM_W-1:0] rd_setup,
  input  logic [NUM_CS-1:0][TIM_W-1:0] rd_strobe,
  input  logic [NUM_CS-1:0][TIM_W-1:0] rd_hold,
  input  logic [NUM_CS-1:0][TIM_W-1:0] wr_setup,
  input  logic [NUM_CS-1:0][TIM_W-1:0] wr_strobe,
  input  logic [NUM_CS-1:0][TIM_W-1:0] wr_hold,
  input  logic [NUM_CS-1:0][TIM_W-1:0] turn,
  input  logic [NUM_CS-1:0]            wide,
  input  logic [NUM_CS-1:0]            sel_strobe,
  input  logic [NUM_CS-1:0]            ext_wait,
  input  logic [CS_W-1:0]              sel,
  output cs_cfg_t                      cfg
);
  always_comb begin
    cfg.rd_setup   = at_least_one(rd_setup[sel]);
    cfg.rd_strobe  = at_least_one(rd_strobe[sel]);
    cfg.rd_hold    = at_least_one(rd_hold[sel]);
    cfg.wr_setup   = at_least_one(wr_setup[sel]);
    cfg.wr_strobe  = at_least_one(wr_strobe[sel]);
    cfg.wr_hold    = at_least_one(wr_hold[sel]);
    cfg.turn       = turn[sel];
    cfg.wide       = wide[sel];
    cfg.sel_strobe = sel_strobe[sel];
    cfg.ext_wait   = ext_wait[sel];
  end
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int WIN_W  = 26,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CS_W-1:0]  req_cs,
  input  logic [WIN_W-1:0] req_off,
  input  logic             req_write,
  input  logic [15:0]      req_wdata,
  input  logic             req_two,
  input  tlen_t            req_turn,
  input  cs_cfg_t          cfg,
  input  logic             wait_now,
  input  logic [15:0]      mem_din,
  output phase_e           phase,
  output logic [CS_W-1:0]  cur_cs,
  output logic             cur_wr,
  output logic [WIN_W-1:0] bus_addr,
  output logic [15:0]      bus_wdata,
  output logic             rsp_valid,
  output logic [15:0]      rsp_rdata,
  output logic             strobe_last,
  output logic             wait_extend,
  output logic             turn_active
);
  tlen_t            cnt;
  tlen_t            len;
  logic             at_end;
  logic [WIN_W-1:0] cur_off;
  logic [15:0]      cur_wdata;
  logic             cur_two;
  logic             upper;
  logic             last_valid;
  logic [CS_W-1:0]  last_cs;
  logic             last_wr;
  logic             need_turn;
  logic             split_more;

  assign len         = phase_len(cfg, cur_wr, phase);
  assign at_end      = (cnt == len - tlen_t'(1));
  assign need_turn   = last_valid && ((last_cs != req_cs) || (last_wr != req_write))
                       && (req_turn != '0);
  assign strobe_last = (phase == PH_STROBE) && at_end;
  assign wait_extend = strobe_last && cfg.ext_wait && wait_now;
  assign turn_active = (phase == PH_TURN);
  assign split_more  = cur_two && !cfg.wide && !upper;
  assign bus_addr    = cur_off + WIN_W'(upper);
  assign bus_wdata   = drive_wr(cur_wdata, cfg.wide, cur_two, upper);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      cur_cs     <= '0;
      cur_off    <= '0;
      cur_wr     <= 1'b0;
      cur_wdata  <= '0;
      cur_two    <= 1'b0;
      upper      <= 1'b0;
      last_valid <= 1'b0;
      last_cs    <= '0;
      last_wr    <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            cur_cs    <= req_cs;
            cur_off   <= req_off;
            cur_wr    <= req_write;
            cur_wdata <= req_wdata;
            cur_two   <= req_two;
            upper     <= 1'b0;
            cnt       <= '0;
            rsp_rdata <= '0;
            phase     <= need_turn ? PH_TURN : PH_SETUP;
          end
        end
        PH_TURN: begin
          if (at_end) begin
            phase <= PH_SETUP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + tlen_t'(1);
          end
        end
        PH_SETUP: begin
          if (at_end) begin
            phase <= PH_STROBE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + tlen_t'(1);
          end
        end
        PH_STROBE: begin
          if (at_end) begin
            if (!wait_extend) begin
              phase <= PH_HOLD;
              cnt   <= '0;
              if (!cur_wr) rsp_rdata <= merge_rd(rsp_rdata, mem_din, cfg.wide, cur_two, upper);
            end
          end else begin
            cnt <= cnt + tlen_t'(1);
          end
        end
        PH_HOLD: begin
          if (at_end) begin
            cnt <= '0;
            if (split_more) begin
              upper <= 1'b1;
              phase <= PH_SETUP;
            end else begin
              phase      <= PH_IDLE;
              rsp_valid  <= 1'b1;
              last_valid <= 1'b1;
              last_cs    <= cur_cs;
              last_wr    <= cur_wr;
            end
          end else begin
            cnt <= cnt + tlen_t'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
  import amc_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int WIN_W   = 26,
  localparam int CS_W   = $clog2(NUM_CS),
  localparam int ADDR_W = WIN_W + CS_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic                         req_write,
  input  logic [15:0]                  req_wdata,
  input  logic                         req_two,
  output logic                         rsp_valid,
  output logic [15:0]                  rsp_rdata,
  input  logic [NUM_CS-1:0][TIM_W-1:0] cfg_rd_setup,
  input  logic [NUM_CS-1:0][TIM_W-1:0] cfg_rd_strobe,
  input  logic [NUM_CS-1:0][TIM_W-1:0] cfg_rd_hold,
  input  logic [NUM_CS-1:0][TIM_W-1:0] cfg_wr_setup,
  input  logic [NUM_CS-1:0][TIM_W-1:0] cfg_wr_strobe,
  input  logic [NUM_CS-1:0][TIM_W-1:0] cfg_wr_hold,
  input  logic [NUM_CS-1:0][TIM_W-1:0] cfg_turn,
  input  logic [NUM_CS-1:0]            cfg_wide,
  input  logic [NUM_CS-1:0]            cfg_sel_strobe,
  input  logic [NUM_CS-1:0]            cfg_ext_wait,
  output logic [NUM_CS-1:0]            mem_cs_n,
  output logic                         mem_oe_n,
  output logic                         mem_we_n,
  output logic [WIN_W-1:0]             mem_addr,
  output logic [15:0]                  mem_dout,
  output logic                         mem_dout_en,
  input  logic [15:0]                  mem_din,
  input  logic [NUM_CS-1:0]            mem_wait
);
  logic [CS_W-1:0]   req_cs;
  logic [WIN_W-1:0]  req_off;
  cs_cfg_t           cfg_req;
  cs_cfg_t           cfg_cur;
  phase_e            phase;
  logic [CS_W-1:0]   cur_cs;
  logic              cur_wr;
  logic [NUM_CS-1:0] wait_s;
  logic              wait_now;
  logic              in_cycle;
  logic              in_strobe;
  logic              cs_active;
  // Named internal events for the bound checker.
  logic              strobe_last;
  logic              wait_extend;
  logic              turn_active;

  assign req_cs  = req_addr[ADDR_W-1:WIN_W];
  assign req_off = req_addr[WIN_W-1:0];

  amc_cfg_sel #(.NUM_CS(NUM_CS)) u_cfg_req (
    .rd_setup(cfg_rd_setup), .rd_strobe(cfg_rd_strobe), .rd_hold(cfg_rd_hold),
    .wr_setup(cfg_wr_setup), .wr_strobe(cfg_wr_strobe), .wr_hold(cfg_wr_hold),
    .turn(cfg_turn), .wide(cfg_wide), .sel_strobe(cfg_sel_strobe),
    .ext_wait(cfg_ext_wait), .sel(req_cs), .cfg(cfg_req)
  );

  amc_cfg_sel #(.NUM_CS(NUM_CS)) u_cfg_cur (
    .rd_setup(cfg_rd_setup), .rd_strobe(cfg_rd_strobe), .rd_hold(cfg_rd_hold),
    .wr_setup(cfg_wr_setup), .wr_strobe(cfg_wr_strobe), .wr_hold(cfg_wr_hold),
    .turn(cfg_turn), .wide(cfg_wide), .sel_strobe(cfg_sel_strobe),
    .ext_wait(cfg_ext_wait), .sel(cur_cs), .cfg(cfg_cur)
  );

  amc_wait_sync #(.WIDTH(NUM_CS)) u_wait_sync (
    .clk(clk), .rst_n(rst_n), .async_in(mem_wait), .sync_out(wait_s)
  );

  assign wait_now = wait_s[cur_cs];

  amc_seq #(.NUM_CS(NUM_CS), .WIN_W(WIN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_cs(req_cs), .req_off(req_off),
    .req_write(req_write), .req_wdata(req_wdata), .req_two(req_two),
    .req_turn(cfg_req.turn), .cfg(cfg_cur), .wait_now(wait_now),
    .mem_din(mem_din), .phase(phase), .cur_cs(cur_cs), .cur_wr(cur_wr),
    .bus_addr(mem_addr), .bus_wdata(mem_dout),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .strobe_last(strobe_last), .wait_extend(wait_extend),
    .turn_active(turn_active)
  );

  assign in_cycle  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign in_strobe = (phase == PH_STROBE);
  assign cs_active = cfg_cur.sel_strobe ? in_strobe : in_cycle;

  assign req_ready   = (phase == PH_IDLE);
  assign mem_oe_n    = !(in_strobe && !cur_wr);
  assign mem_we_n    = !(in_strobe && cur_wr);
  assign mem_dout_en = in_cycle && cur_wr;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign mem_cs_n[g] = !(cs_active && (cur_cs == CS_W'(g)));
  end
endmodule

// File: rtl/amc_checker.sv
module amc_checker #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [NUM_CS-1:0] mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dout_en,
  input logic              strobe_last,
  input logic              wait_extend,
  input logic              turn_active
);
  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  p_turn_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    turn_active |-> (&mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en));

  p_strobe_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

  p_wait_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_extend |=> (!mem_oe_n || !mem_we_n));

  p_strobe_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_last && !wait_extend) |=> (mem_oe_n && mem_we_n));

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && &mem_cs_n));

  p_read_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dout_en);

  p_write_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dout_en);

  p_ready_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind async_mem_ctrl amc_checker #(.NUM_CS(NUM_CS)) u_amc_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dout_en(mem_dout_en), .strobe_last(strobe_last),
  .wait_extend(wait_extend), .turn_active(turn_active)
);

// File: tb/test_async_mem_ctrl.sv
module test_async_mem_ctrl;
  localparam int NUM_CS = 4;
  localparam int WIN_W  = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [27:0]       req_addr = '0;
  logic              req_write = 1'b0;
  logic [15:0]       req_wdata = '0;
  logic              req_two = 1'b0;
  logic              rsp_valid;
  logic [15:0]       rsp_rdata;
  logic [NUM_CS-1:0][3:0] c_rsu = '0, c_rst = '0, c_rhd = '0;
  logic [NUM_CS-1:0][3:0] c_wsu = '0, c_wst = '0, c_whd = '0, c_ta = '0;
  logic [NUM_CS-1:0] c_wide = '0, c_ss = '0, c_ew = '0;
  logic [NUM_CS-1:0] mem_cs_n;
  logic              mem_oe_n, mem_we_n, mem_dout_en;
  logic [WIN_W-1:0]  mem_addr;
  logic [15:0]       mem_dout;
  logic [15:0]       mem_din;
  logic [NUM_CS-1:0] mem_wait = '0;

  // Memory model: each byte lane derived from the byte address.
  assign mem_din = {mem_addr[7:0] ^ 8'hA5, mem_addr[7:0] ^ 8'h5A};

  async_mem_ctrl i_async_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_two(req_two), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_rd_setup(c_rsu), .cfg_rd_strobe(c_rst), .cfg_rd_hold(c_rhd),
    .cfg_wr_setup(c_wsu), .cfg_wr_strobe(c_wst), .cfg_wr_hold(c_whd),
    .cfg_turn(c_ta), .cfg_wide(c_wide), .cfg_sel_strobe(c_ss),
    .cfg_ext_wait(c_ew), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_wait(mem_wait)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Measurements of the last access.
  int m_cs, m_other, m_oe, m_we, m_den, m_lead, m_cs_seg, m_oe_seg, m_we_seg;
  int m_ready, m_cs_bare, wait_release;
  logic m_done;
  logic [15:0] m_rdata;
  logic [WIN_W-1:0] ra [4];
  logic [WIN_W-1:0] wa [4];
  logic [15:0]      wd [4];

  task automatic run(input logic [1:0] cs, input logic [25:0] off, input logic wr,
                     input logic [15:0] wdat, input logic two);
    logic seen, p_cs, p_oe, p_we, cs_l;
    @(negedge clk);
    req_valid = 1'b1; req_addr = {cs, off}; req_write = wr;
    req_wdata = wdat; req_two = two;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    m_cs = 0; m_other = 0; m_oe = 0; m_we = 0; m_den = 0; m_lead = 0;
    m_cs_seg = 0; m_oe_seg = 0; m_we_seg = 0; m_ready = 0; m_cs_bare = 0;
    m_done = 1'b0; m_rdata = '0;
    seen = 1'b0; p_cs = 1'b0; p_oe = 1'b1; p_we = 1'b1;
    for (int i = 0; i < 400; i++) begin
      if (rsp_valid) begin
        m_done = 1'b1; m_rdata = rsp_rdata;
        break;
      end
      cs_l = !mem_cs_n[cs];
      if (cs_l) m_cs++;
      if (cs_l && !p_cs) m_cs_seg++;
      if (((~mem_cs_n) & ~(4'b0001 << cs)) != 4'b0000) m_other++;
      if (!seen && !cs_l) m_lead++;
      if (cs_l) seen = 1'b1;
      if (!mem_oe_n) begin
        m_oe++;
        if (p_oe) begin
          if (m_oe_seg < 4) ra[m_oe_seg] = mem_addr;
          m_oe_seg++;
        end
        if (wait_release != 0 && m_oe == wait_release) mem_wait = '0;
      end
      if (!mem_we_n) begin
        m_we++;
        if (p_we) begin
          if (m_we_seg < 4) begin wa[m_we_seg] = mem_addr; wd[m_we_seg] = mem_dout; end
          m_we_seg++;
        end
      end
      if (mem_dout_en) m_den++;
      if (cs_l && mem_oe_n && mem_we_n) m_cs_bare++;
      if (req_ready) m_ready++;
      p_cs = cs_l; p_oe = mem_oe_n; p_we = mem_we_n;
      @(negedge clk);
    end
    check("R9", "response seen", 32'(m_done), 32'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10", "ready", 32'(req_ready), 32'd1);
    check("R10", "cs_n", 32'(mem_cs_n), 32'hF);
    check("R10", "oe_n/we_n", 32'({mem_oe_n, mem_we_n}), 32'h3);
    check("R10", "dout_en/rsp", 32'({mem_dout_en, rsp_valid}), 32'h0);
  endtask

  task automatic t_read_write_basic();
    c_rsu[1] = 4'd2; c_rst[1] = 4'd3; c_rhd[1] = 4'd1;
    c_wsu[1] = 4'd1; c_wst[1] = 4'd4; c_whd[1] = 4'd2;
    c_wide[1] = 1'b1;
    run(2'd1, 26'h0000120, 1'b0, 16'h0, 1'b1);
    check("R2", "read cs cycles", 32'(m_cs), 32'd6);
    check("R2", "read oe cycles", 32'(m_oe), 32'd3);
    check("R1", "other cs low", 32'(m_other), 32'd0);
    check("R1", "read address", 32'(ra[0]), 32'h120);
    check("R9", "read word", 32'(m_rdata), 32'h857A);
    check("R11", "no drive on read", 32'(m_den + m_we), 32'd0);
    check("R12", "ready during access", 32'(m_ready), 32'd0);
    @(negedge clk);
    check("R9", "pulse one cycle", 32'(rsp_valid), 32'd0);
    run(2'd1, 26'h0000200, 1'b1, 16'hBEEF, 1'b1);
    check("R2", "write cs cycles", 32'(m_cs), 32'd7);
    check("R2", "write we cycles", 32'(m_we), 32'd4);
    check("R2", "no oe on write", 32'(m_oe), 32'd0);
    check("R11", "drive cycles", 32'(m_den), 32'd7);
    check("R11", "write data", 32'(wd[0]), 32'hBEEF);
    check("R1", "write address", 32'(wa[0]), 32'h200);
    check("R4", "zero turn no lead", 32'(m_lead), 32'd0);
  endtask

  task automatic t_zero_len();
    c_wide[2] = 1'b1;
    run(2'd2, 26'h0000010, 1'b0, 16'h0, 1'b1);
    check("R3", "zero timing cs cycles", 32'(m_cs), 32'd3);
    check("R3", "zero timing strobe", 32'(m_oe), 32'd1);
  endtask

  task automatic t_turnaround();
    c_rsu[3] = 4'd1; c_rst[3] = 4'd1; c_rhd[3] = 4'd1;
    c_wsu[3] = 4'd1; c_wst[3] = 4'd1; c_whd[3] = 4'd1;
    c_ta[3] = 4'd3; c_wide[3] = 1'b1;
    run(2'd3, 26'h0000001, 1'b0, 16'h0, 1'b0);
    check("R4", "new cs lead", 32'(m_lead), 32'd3);
    run(2'd3, 26'h0000002, 1'b0, 16'h0, 1'b0);
    check("R5", "read after read lead", 32'(m_lead), 32'd0);
    run(2'd3, 26'h0000003, 1'b1, 16'h00AA, 1'b0);
    check("R4", "direction change lead", 32'(m_lead), 32'd3);
    run(2'd3, 26'h0000004, 1'b1, 16'h0055, 1'b0);
    check("R5", "write after write lead", 32'(m_lead), 32'd0);
    check("R2", "one-cycle phases", 32'(m_cs), 32'd3);
  endtask

  task automatic t_sel_strobe();
    c_rsu[0] = 4'd2; c_rst[0] = 4'd2; c_rhd[0] = 4'd2;
    c_wide[0] = 1'b1; c_ss[0] = 1'b1;
    run(2'd0, 26'h0000040, 1'b0, 16'h0, 1'b1);
    check("R6", "cs only in strobe", 32'(m_cs), 32'd2);
    check("R6", "cs without strobe", 32'(m_cs_bare), 32'd0);
    check("R6", "strobe length", 32'(m_oe), 32'd2);
    c_ss[0] = 1'b0;
    run(2'd0, 26'h0000040, 1'b0, 16'h0, 1'b1);
    check("R6", "full-cycle cs", 32'(m_cs), 32'd6);
  endtask

  task automatic t_ext_wait();
    c_ew[0] = 1'b1;
    @(negedge clk); mem_wait[0] = 1'b1;
    wait_release = 5;
    run(2'd0, 26'h0000050, 1'b0, 16'h0, 1'b1);
    wait_release = 0;
    check("R7", "stretched strobe", 32'(m_oe), 32'd7);
    check("R7", "data after stretch", 32'(m_rdata), 32'hF50A);
    c_ew[0] = 1'b0;
    @(negedge clk); mem_wait[0] = 1'b1;
    run(2'd0, 26'h0000050, 1'b0, 16'h0, 1'b1);
    check("R7", "wait ignored mode off", 32'(m_oe), 32'd2);
    c_ew[0] = 1'b1; mem_wait = 4'b0010;
    run(2'd0, 26'h0000050, 1'b0, 16'h0, 1'b1);
    check("R7", "other cs wait ignored", 32'(m_oe), 32'd2);
    mem_wait = '0;
    c_ew[0] = 1'b0;
  endtask

  task automatic t_narrow();
    c_wide[2] = 1'b0; c_ta[2] = 4'd2;
    c_rsu[2] = 4'd1; c_rst[2] = 4'd2; c_rhd[2] = 4'd1;
    c_wsu[2] = 4'd1; c_wst[2] = 4'd1; c_whd[2] = 4'd1;
    run(2'd2, 26'h0000ABC, 1'b0, 16'h0, 1'b1);
    check("R4", "lead into cs2", 32'(m_lead), 32'd2);
    check("R8", "split strobes", 32'(m_oe_seg), 32'd2);
    check("R8", "cs unbroken", 32'(m_cs_seg), 32'd1);
    check("R8", "cs cycles both halves", 32'(m_cs), 32'd8);
    check("R8", "low half address", 32'(ra[0]), 32'hABC);
    check("R8", "high half address", 32'(ra[1]), 32'hABD);
    check("R9", "split read word", 32'(m_rdata), 32'hE7E6);
    run(2'd2, 26'h0000077, 1'b0, 16'h0, 1'b0);
    check("R9", "byte read", 32'(m_rdata), 32'h002D);
    check("R8", "byte single access", 32'(m_oe_seg), 32'd1);
    run(2'd2, 26'h0000100, 1'b1, 16'h1234, 1'b1);
    check("R4", "write after read lead", 32'(m_lead), 32'd2);
    check("R8", "split writes", 32'(m_we_seg), 32'd2);
    check("R8", "first write byte", 32'({wa[0][11:0], wd[0]}), 32'h1000034);
    check("R8", "second write byte", 32'({wa[1][11:0], wd[1]}), 32'h1010012);
    check("R11", "drive both halves", 32'(m_den), 32'd6);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_release = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_read_write_basic();
    t_zero_len();
    t_turnaround();
    t_sel_strobe();
    t_ext_wait();
    t_narrow();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule